// File: doc/BRIEF.md
# Character Stream Byte Reader

This block pulls the next 8-bit character out of a byte stream that is packed two characters per 16-bit memory word. A two-word descriptor in memory describes the stream. The first word holds a byte-position flag in its top bit and a 15-bit count of the bytes that remain. The second word holds the address of the data word being consumed. A requester hands over the descriptor address and a mode value. The block then reads the descriptor and the data word through a single-ported word memory interface, writes the updated descriptor back in place, and answers with one response.

The response reports one of three outcomes. The first is exhausted, meaning the count was zero and memory was left untouched. The second is success, which carries the character zero-extended to 16 bits. The third is a misalignment error, raised when the descriptor address is odd. One mode value turns on folding of lower-case ASCII letters to upper case. All other mode values return the byte as it is stored. The block only reports the outcome. Whatever the caller does with that outcome, such as skipping an instruction, is outside the block.

Top module: `csr_reader`

## Requirements
- R1: When the 15-bit count (word 0 bits 14..0) is zero, the response has rsp_empty=1 and rsp_char=0, whatever the value of the flag bit. No memory write happens, and both descriptor words keep their values.
- R2: On success, word 0 is rewritten as its old value plus 16'h7FFF, modulo 2^16. This decrements the count and inverts bit 15 in one step.
- R3: When bit 15 of word 0 is 0, the character is bits 15..8 of the data word, and word 1 is left unchanged.
- R4: When bit 15 of word 0 is 1, the character is bits 7..0 of the data word, and word 1 is rewritten as its old value plus 1, modulo 2^16.
- R5: With req_mode=16'h0000, the byte is returned unchanged, lower-case letters included.
- R6: With req_mode=16'h0060, bytes from 8'h61 to 8'h7A inclusive are returned minus 8'h20. The bytes 8'h60 and 8'h7B are returned unchanged.
- R7: Any req_mode other than 16'h0060 behaves as 16'h0000.
- R8: A success response has rsp_empty=0 and rsp_err=0, and rsp_char[15:8]=0.
- R9: An odd req_addr (bit 0 = 1) gives rsp_err=1, rsp_empty=0 and rsp_char=0, with no memory read or write.
- R10: After reset, req_ready=1, and rsp_valid, mem_rd and mem_wr are 0.
- R11: Each accepted request produces exactly one rsp_valid pulse of one cycle. req_ready stays 0 from acceptance until that pulse, and mem_rd and mem_wr are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is 1 |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | ADDR_W | Word address of descriptor word 0 |
| req_mode | input | 16 | Mode; 16'h0060 selects upper-case folding |
| mem_rd | output | 1 | Memory read strobe; data returns on mem_rdata the next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after mem_rd |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_empty | output | 1 | Stream was exhausted |
| rsp_err | output | 1 | Descriptor address was odd |
| rsp_char | output | 16 | Character, zero-extended |

## Verification
The stimulus covers both values of the flag bit, so both the high-byte path and the low-byte path are exercised. The pointer-increment path is driven into its wrap from 16'hFFFF to 0. The count is tried at zero, at one, at its maximum, and with the top bit of the word carrying into bit 15. These values separate a proper single-step addition from a separate decrement or a plain flag toggle. The folding window is probed at 8'h61 and 8'h7A and just outside it, at 8'h60 and 8'h7B, in the folding mode, in mode zero, and in an unrelated mode one step off. Together these show that the range test and the mode compare are exact. Exhausted and misaligned requests are checked for the absence of memory traffic as well as for the response flags.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = DATA_W - 1;
  localparam logic [DATA_W-1:0] HDR_STEP  = {1'b0, {CNT_W{1'b1}}};
  localparam logic [DATA_W-1:0] FOLD_MODE = 16'h0060;
  localparam logic [BYTE_W-1:0] LC_LO     = 8'h61;
  localparam logic [BYTE_W-1:0] LC_HI     = 8'h7A;
  localparam logic [BYTE_W-1:0] CASE_DIFF = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_HDR, ST_RD_PTR, ST_CHECK,
    ST_FETCH, ST_WR_HDR, ST_WR_PTR, ST_RESP
  } csr_state_e;
endpackage

// File: rtl/csr_desc_next.sv
module csr_desc_next
  import csr_pkg::*;
(
  input  logic [DATA_W-1:0] hdr,
  input  logic [DATA_W-1:0] ptr,
  output logic              empty,
  output logic              odd,
  output logic [DATA_W-1:0] hdr_next,
  output logic [DATA_W-1:0] ptr_next
);
  always_comb begin
    empty    = (hdr[CNT_W-1:0] == '0);
    odd      = hdr[DATA_W-1];
    hdr_next = hdr + HDR_STEP;
    ptr_next = ptr + 1'b1;
  end
endmodule

// File: rtl/csr_byte_pick.sv
module csr_byte_pick
  import csr_pkg::*;
(
  input  logic [DATA_W-1:0] word,
  input  logic              low_sel,
  input  logic [DATA_W-1:0] mode,
  output logic [DATA_W-1:0] chr
);
  logic [BYTE_W-1:0] raw;
  logic              fold;

  always_comb begin
    raw  = low_sel ? word[BYTE_W-1:0] : word[DATA_W-1:DATA_W-BYTE_W];
    fold = (mode == FOLD_MODE) && (raw >= LC_LO) && (raw <= LC_HI);
    chr  = {{(DATA_W-BYTE_W){1'b0}}, fold ? (raw - CASE_DIFF) : raw};
  end
endmodule

// File: rtl/csr_reader.sv
module csr_reader
  import csr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_mode,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rsp_valid,
  output logic              rsp_empty,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_char
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  csr_state_e        state_q, state_n;
  logic [ADDR_W-1:0] base_q, base_n;
  logic [DATA_W-1:0] mode_q, mode_n;
  logic [DATA_W-1:0] hdr_q, hdr_n;
  logic [DATA_W-1:0] ptr_q, ptr_n;
  logic [DATA_W-1:0] chr_q, chr_n;
  logic              empty_q, empty_n;
  logic              err_q, err_n;
  logic              ctx_en, res_en;

  logic              d_empty, d_odd;
  logic [DATA_W-1:0] d_hdr_next, d_ptr_next, picked;
  logic [ADDR_W-1:0] base_w1;

  assign base_w1 = {base_q[ADDR_W-1:1], 1'b1};

  csr_desc_next u_desc (
    .hdr      (hdr_q),
    .ptr      (ptr_q),
    .empty    (d_empty),
    .odd      (d_odd),
    .hdr_next (d_hdr_next),
    .ptr_next (d_ptr_next)
  );

  csr_byte_pick u_pick (
    .word    (mem_rdata),
    .low_sel (d_odd),
    .mode    (mode_q),
    .chr     (picked)
  );

  always_comb begin
    state_n   = state_q;
    base_n    = base_q;
    mode_n    = mode_q;
    hdr_n     = hdr_q;
    ptr_n     = ptr_q;
    chr_n     = chr_q;
    empty_n   = empty_q;
    err_n     = err_q;
    ctx_en    = 1'b0;
    res_en    = 1'b0;
    mem_rd    = 1'b0;
    mem_wr    = 1'b0;
    mem_addr  = base_q;
    mem_wdata = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ctx_en = 1'b1;
          base_n = req_addr;
          mode_n = req_mode;
          if (req_addr[0]) begin
            res_en  = 1'b1;
            err_n   = 1'b1;
            empty_n = 1'b0;
            chr_n   = '0;
            state_n = ST_RESP;
          end else begin
            state_n = ST_RD_HDR;
          end
        end
      end
      ST_RD_HDR: begin
        mem_rd  = 1'b1;
        state_n = ST_RD_PTR;
      end
      ST_RD_PTR: begin
        mem_rd   = 1'b1;
        mem_addr = base_w1;
        ctx_en   = 1'b1;
        hdr_n    = mem_rdata;
        state_n  = ST_CHECK;
      end
      ST_CHECK: begin
        ctx_en = 1'b1;
        ptr_n  = mem_rdata;
        if (d_empty) begin
          res_en  = 1'b1;
          err_n   = 1'b0;
          empty_n = 1'b1;
          chr_n   = '0;
          state_n = ST_RESP;
        end else begin
          state_n = ST_FETCH;
        end
      end
      ST_FETCH: begin
        mem_rd   = 1'b1;
        mem_addr = ptr_q[ADDR_W-1:0];
        state_n  = ST_WR_HDR;
      end
      ST_WR_HDR: begin
        mem_wr    = 1'b1;
        mem_wdata = d_hdr_next;
        res_en    = 1'b1;
        err_n     = 1'b0;
        empty_n   = 1'b0;
        chr_n     = picked;
        state_n   = d_odd ? ST_WR_PTR : ST_RESP;
      end
      ST_WR_PTR: begin
        mem_wr    = 1'b1;
        mem_addr  = base_w1;
        mem_wdata = d_ptr_next;
        state_n   = ST_RESP;
      end
      ST_RESP: state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_n;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      base_q <= '0;
      mode_q <= '0;
      hdr_q  <= '0;
      ptr_q  <= '0;
    end else if (ctx_en) begin
      base_q <= base_n;
      mode_q <= mode_n;
      hdr_q  <= hdr_n;
      ptr_q  <= ptr_n;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      chr_q   <= '0;
      empty_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (res_en) begin
      chr_q   <= chr_n;
      empty_q <= empty_n;
      err_q   <= err_n;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_empty = empty_q;
  assign rsp_err   = err_q;
  assign rsp_char  = chr_q;
endmodule

// File: rtl/csr_reader_chk.sv
module csr_reader_chk
  import csr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              rsp_valid,
  input logic              rsp_empty,
  input logic              rsp_err,
  input logic [DATA_W-1:0] rsp_char
);
  AST_EMPTY_NO_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_empty) |-> (rsp_char == '0)); // R1
  AST_CHAR_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_char[DATA_W-1:BYTE_W] == '0)); // R8
  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> $past(!mem_rd && !mem_wr)); // R9
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_empty && rsp_err)); // R9
  AST_BUSY_WHILE_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R11
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R11
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R11
endmodule

bind csr_reader csr_reader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .rsp_valid (rsp_valid),
  .rsp_empty (rsp_empty),
  .rsp_err   (rsp_err),
  .rsp_char  (rsp_char)
);

// File: tb/csr_reader_tb_top.sv
module csr_reader_tb_top;
  localparam int AW = 16;
  localparam int NV = 12;
  localparam logic [AW-1:0] DESC = 16'h0008;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_mode = '0;
  logic mem_rd, mem_wr;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic rsp_valid, rsp_empty, rsp_err;
  logic [15:0] rsp_char;

  logic [15:0] mem [0:63];
  int n_acc = 0;
  int n_wr = 0;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  csr_reader #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mode(req_mode),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_empty(rsp_empty),
    .rsp_err(rsp_err), .rsp_char(rsp_char)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];
    if (mem_wr) mem[mem_addr[5:0]] <= mem_wdata;
    if (mem_rd || mem_wr) n_acc <= n_acc + 1;
    if (mem_wr) n_wr <= n_wr + 1;
  end

  // {hdr, ptr, data, mode, exp_empty, exp_char, exp_hdr, exp_ptr}
  localparam logic [127:0] VECS [0:NV-1] = '{
    {16'h0003,16'h0014,16'h4142,16'h0000,16'h0000,16'h0041,16'h8002,16'h0014}, // R3 R2
    {16'h8002,16'h0014,16'h4162,16'h0060,16'h0000,16'h0042,16'h0001,16'h0015}, // R4 R6
    {16'h0000,16'h0014,16'h4142,16'h0000,16'h0001,16'h0000,16'h0000,16'h0014}, // R1
    {16'h8000,16'h0014,16'h4142,16'h0060,16'h0001,16'h0000,16'h8000,16'h0014}, // R1
    {16'h0001,16'h0014,16'h6A00,16'h0000,16'h0000,16'h006A,16'h8000,16'h0014}, // R5
    {16'h0005,16'h0014,16'h6100,16'h0060,16'h0000,16'h0041,16'h8004,16'h0014}, // R6
    {16'h8005,16'h0014,16'h007A,16'h0060,16'h0000,16'h005A,16'h0004,16'h0015}, // R6
    {16'h0002,16'h0014,16'h6000,16'h0060,16'h0000,16'h0060,16'h8001,16'h0014}, // R6
    {16'h8002,16'h0014,16'h007B,16'h0060,16'h0000,16'h007B,16'h0001,16'h0015}, // R6
    {16'h0002,16'h0014,16'h6100,16'h0061,16'h0000,16'h0061,16'h8001,16'h0014}, // R7
    {16'h7FFF,16'h0014,16'hFF00,16'h0000,16'h0000,16'h00FF,16'hFFFE,16'h0014}, // R8 R2
    {16'h8001,16'hFFFF,16'h12E4,16'h0000,16'h0000,16'h00E4,16'h0000,16'h0000}  // R4 wrap
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_req(input logic [AW-1:0] a, input logic [15:0] m, output bit ok);
    ok = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = a;
    req_mode = m;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 busy after accept", {31'd0, req_ready}, 32'd0);
    for (int i = 0; i < 40; i++) begin
      if (rsp_valid) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    chk("R11 response seen", {31'd0, ok}, 32'd1);
    if (ok) begin
      @(negedge clk);
      chk("R11 single pulse", {31'd0, rsp_valid}, 32'd0);
      chk("R11 ready after rsp", {31'd0, req_ready}, 32'd1);
    end
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit ok;
    logic [127:0] v;
    int acc0, wr0;
    for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    chk("R10 ready", {31'd0, req_ready}, 32'd1);
    chk("R10 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R10 mem idle", {30'd0, mem_rd, mem_wr}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 ready after release", {31'd0, req_ready}, 32'd1);

    for (int k = 0; k < NV; k++) begin
      v = VECS[k];
      mem[DESC[5:0]] = v[127:112];
      mem[DESC[5:0] + 6'd1] = v[111:96];
      mem[v[101:96]] = v[95:80];
      wr0 = n_wr;
      run_req(DESC, v[79:64], ok);
      if (ok) begin
        chk($sformatf("R1/R8 empty flag v%0d", k), {31'd0, rsp_empty}, {31'd0, v[48]});
        chk($sformatf("R8 err clear v%0d", k), {31'd0, rsp_err}, 32'd0);
        chk($sformatf("R3 R4 R5 R6 R7 char v%0d", k), {16'd0, rsp_char}, {16'd0, v[47:32]});
        chk($sformatf("R2 word0 v%0d", k), {16'd0, mem[DESC[5:0]]}, {16'd0, v[31:16]});
        chk($sformatf("R3 R4 word1 v%0d", k), {16'd0, mem[DESC[5:0] + 6'd1]}, {16'd0, v[15:0]});
        if (v[48]) chk($sformatf("R1 no write v%0d", k), n_wr - wr0, 32'd0);
      end
    end

    // R9: odd descriptor address
    acc0 = n_acc;
    run_req(16'h0009, 16'h0000, ok);
    if (ok) begin
      chk("R9 err flag", {31'd0, rsp_err}, 32'd1);
      chk("R9 empty clear", {31'd0, rsp_empty}, 32'd0);
      chk("R9 char zero", {16'd0, rsp_char}, 32'd0);
    end
    chk("R9 no memory access", n_acc - acc0, 32'd0);

    // request ignored while busy (R11): second strobe mid-flight changes nothing
    mem[DESC[5:0]] = 16'h0001;
    mem[DESC[5:0] + 6'd1] = 16'h0014;
    mem[20] = 16'h5A00;
    @(negedge clk);
    req_valid = 1'b1; req_addr = DESC; req_mode = 16'h0000;
    @(negedge clk);
    req_addr = 16'h0009;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    ok = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (rsp_valid) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    chk("R11 busy strobe ignored err", {31'd0, rsp_err}, 32'd0);
    chk("R11 busy strobe char", {16'd0, rsp_char}, 32'h005A);
    @(negedge clk);
    chk("R11 no second response", {31'd0, rsp_valid}, 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule